// File: doc/BRIEF.md
# Dual-Mode CPU Transfer Buffer

This block holds a 256-byte, 8-bit-wide store that two clients share. One is a CPU register port and the other is a serial transfer engine. The store has two pointers, a write pointer and a read pointer. Each one advances by one after every data access that uses it. A CPU that always reads or writes the single data register therefore sees a FIFO.

Both pointers are also CPU registers that can be read and written. Loading a pointer before a data access lets software reach any chosen byte. The same storage can therefore act as a random-access RAM.

The engine has its own byte write and byte read strobes. These use and advance the same two pointers. When the engine and the CPU want the store in the same cycle, the engine goes first and the CPU request waits. Pointers wrap around and are never blocked, so software must track the fill level itself.

Top module: `xbuf_top`

## Requirements
- R1: After reset, both pointers are 0 and neither `cpu_rvalid` nor `eng_rvalid` is asserted.
- R2: The CPU register select `cpu_addr` decodes as follows: 0 is the data port, 1 is the write pointer and 2 is the read pointer. Select 3 is unused. A read of select 3 returns 0, and a write to it changes neither pointer nor any stored byte.
- R3: An accepted CPU write to the data port stores `cpu_wdata` at the write pointer and advances the write pointer by one.
- R4: An accepted CPU read of any select raises `cpu_rvalid` for exactly the next cycle, with `cpu_rdata` valid in that cycle. For the data port the value is the byte at the read pointer, and that same strobe advances the read pointer by one.
- R5: Reading select 1 or select 2 returns the pointer's value at the time the read is accepted, zero-extended.
- R6: Writing select 1 or select 2 loads that pointer from the low bits of `cpu_wdata`. The next data access of that kind then uses the loaded byte position.
- R7: Pointers wrap from 255 to 0. No write or read is ever refused on the basis of fill level.
- R8: An `eng_wr` strobe stores `eng_wdata` at the write pointer and advances it. An `eng_rd` strobe returns the byte at the read pointer on `eng_rdata` in the next cycle, with `eng_rvalid` high, and advances the read pointer.
- R9: When `cpu_sel` is high in a cycle with an engine strobe, the engine access is performed and `cpu_stall` is high. The CPU access has no effect in that cycle. A CPU request that is held is then completed in the first cycle with no engine strobe.
- R10: When the engine reads and writes the same byte position in one cycle, the read returns the byte's previous contents and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU register access request; held until not stalled |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register select (0 data, 1 write pointer, 2 read pointer, 3 unused) |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read result |
| cpu_rvalid | output | 1 | One-cycle pulse marking `cpu_rdata` valid |
| cpu_stall | output | 1 | CPU request not taken this cycle |
| eng_wr | input | 1 | Engine byte write strobe |
| eng_wdata | input | DATA_W | Engine write data |
| eng_rd | input | 1 | Engine byte read strobe |
| eng_rdata | output | DATA_W | Engine read result |
| eng_rvalid | output | 1 | One-cycle pulse marking `eng_rdata` valid |

## Verification
A pointer that slips or fails to advance first shows at the ports in two ways. The next pointer read-back returns the wrong value, and the next data read returns a byte from the wrong position. Either shows one cycle after the affected access is accepted. A wrong arbitration decision appears at once as a missing or extra `cpu_stall` cycle. It then shows as an engine byte that lands at a different position than expected, or a CPU byte that overwrites it. A read-before-write error is exposed by the first engine read that coincides with a write to the same position.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

   // CPU register selects (decoded by the register port)
   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_WPTR = 2'd1,
      SEL_RPTR = 2'd2,
      SEL_NONE = 2'd3
   } xbuf_sel_e;

   // Index of each pointer unit in the pointer bank
   localparam int PTR_WR = 0;
   localparam int PTR_RD = 1;
   localparam int N_PTR  = 2;

   // Per-pointer control produced by arbitration
   typedef struct packed {
      logic ld;
      logic inc;
   } ptr_ctl_t;

endpackage

// File: rtl/xbuf_ptr.sv
module xbuf_ptr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xbuf_pkg::ptr_ctl_t ctl,
   input  logic [ADDR_W-1:0] ld_val,
   output logic [ADDR_W-1:0] ptr
);

   // A load takes precedence; increments wrap naturally at 2**ADDR_W
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ctl.ld) begin
         ptr <= ld_val;
      end else if (ctl.inc) begin
         ptr <= ptr + 1'b1;
      end
   end

endmodule

// File: rtl/xbuf_arb.sv
module xbuf_arb #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic                   cpu_sel,
   input  logic                   cpu_wr,
   input  logic [1:0]             cpu_addr,
   input  logic [DATA_W-1:0]      cpu_wdata,
   input  logic                   eng_wr,
   input  logic                   eng_rd,
   input  logic [DATA_W-1:0]      eng_wdata,
   output logic                   cpu_go,
   output logic                   cpu_stall,
   output logic                   mem_we,
   output logic [DATA_W-1:0]      mem_wdata,
   output xbuf_pkg::ptr_ctl_t     ptr_ctl [xbuf_pkg::N_PTR],
   output logic [ADDR_W-1:0]      ld_val
);
   import xbuf_pkg::*;

   logic eng_busy;
   logic cpu_dwr, cpu_drd, cpu_lw, cpu_lr;

   assign eng_busy  = eng_wr | eng_rd;
   assign cpu_go    = cpu_sel & ~eng_busy;
   assign cpu_stall = cpu_sel &  eng_busy;

   always_comb begin
      cpu_dwr = 1'b0;
      cpu_drd = 1'b0;
      cpu_lw  = 1'b0;
      cpu_lr  = 1'b0;
      if (cpu_go) begin
         unique case (xbuf_sel_e'(cpu_addr))
            SEL_DATA: begin
               cpu_dwr = cpu_wr;
               cpu_drd = ~cpu_wr;
            end
            SEL_WPTR: cpu_lw = cpu_wr;
            SEL_RPTR: cpu_lr = cpu_wr;
            SEL_NONE: ;
            default:  ;
         endcase
      end
   end

   // Engine owns the store whenever it strobes; the CPU is idle then
   assign mem_we    = eng_wr | cpu_dwr;
   assign mem_wdata = eng_wr ? eng_wdata : cpu_wdata;
   assign ld_val    = cpu_wdata[ADDR_W-1:0];

   always_comb begin
      ptr_ctl[PTR_WR].ld  = cpu_lw;
      ptr_ctl[PTR_WR].inc = eng_wr | cpu_dwr;
      ptr_ctl[PTR_RD].ld  = cpu_lr;
      ptr_ctl[PTR_RD].inc = eng_rd | cpu_drd;
   end

endmodule

// File: rtl/xbuf_store.sv
module xbuf_store #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Combinational look-up: a same-cycle write is not yet visible
   assign rdata = mem[raddr];

endmodule

// File: rtl/xbuf_top.sv
module xbuf_top #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic [1:0]        cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_rvalid,
   output logic              cpu_stall,
   input  logic              eng_wr,
   input  logic [DATA_W-1:0] eng_wdata,
   input  logic              eng_rd,
   output logic [DATA_W-1:0] eng_rdata,
   output logic              eng_rvalid
);
   import xbuf_pkg::*;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("xbuf_top: ADDR_W must lie in 1..12");
      end
      if (DATA_W < ADDR_W) begin : g_bad_data
         $error("xbuf_top: DATA_W must hold a full pointer for read-back");
      end
   endgenerate

   logic                 cpu_go;
   logic                 mem_we;
   logic [DATA_W-1:0]    mem_wdata;
   logic [DATA_W-1:0]    mem_rdata;
   logic [ADDR_W-1:0]    ld_val;
   ptr_ctl_t             ptr_ctl [N_PTR];
   logic [ADDR_W-1:0]    ptrs    [N_PTR];
   logic [ADDR_W-1:0]    wr_ptr, rd_ptr;
   logic [DATA_W-1:0]    cpu_rsp;

   xbuf_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arb (
      .cpu_sel   (cpu_sel),
      .cpu_wr    (cpu_wr),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .eng_wr    (eng_wr),
      .eng_rd    (eng_rd),
      .eng_wdata (eng_wdata),
      .cpu_go    (cpu_go),
      .cpu_stall (cpu_stall),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .ptr_ctl   (ptr_ctl),
      .ld_val    (ld_val)
   );

   for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
      xbuf_ptr #(.ADDR_W(ADDR_W)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .ctl    (ptr_ctl[g]),
         .ld_val (ld_val),
         .ptr    (ptrs[g])
      );
   end

   assign wr_ptr = ptrs[PTR_WR];
   assign rd_ptr = ptrs[PTR_RD];

   xbuf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (wr_ptr),
      .wdata (mem_wdata),
      .raddr (rd_ptr),
      .rdata (mem_rdata)
   );

   // CPU read response source
   always_comb begin
      unique case (xbuf_sel_e'(cpu_addr))
         SEL_DATA: cpu_rsp = mem_rdata;
         SEL_WPTR: cpu_rsp = DATA_W'(wr_ptr);
         SEL_RPTR: cpu_rsp = DATA_W'(rd_ptr);
         default:  cpu_rsp = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_rdata  <= '0;
         cpu_rvalid <= 1'b0;
         eng_rdata  <= '0;
         eng_rvalid <= 1'b0;
      end else begin
         cpu_rvalid <= cpu_go & ~cpu_wr;
         eng_rvalid <= eng_rd;
         if (cpu_go && !cpu_wr) cpu_rdata <= cpu_rsp;
         if (eng_rd)            eng_rdata <= mem_rdata;
      end
   end

endmodule

// File: rtl/xbuf_chk.sv
module xbuf_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_sel,
   input logic              cpu_wr,
   input logic [1:0]        cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_stall,
   input logic              cpu_rvalid,
   input logic              eng_wr,
   input logic              eng_rd,
   input logic              eng_rvalid,
   input logic [ADDR_W-1:0] wr_ptr,
   input logic [ADDR_W-1:0] rd_ptr
);

   logic cpu_take;
   assign cpu_take = cpu_sel && !cpu_stall;

   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_take && cpu_wr && cpu_addr == 2'd0) |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1))); // R3

   AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_take && !cpu_wr && cpu_addr == 2'd0) |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1))); // R4

   AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> $past(cpu_take && !cpu_wr)); // R4

   AST_WPTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_take && cpu_wr && cpu_addr == 2'd1) |=> (wr_ptr == $past(cpu_wdata[ADDR_W-1:0]))); // R6

   AST_STALL_KEEPS_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stall && !eng_wr) |=> $stable(wr_ptr)); // R9

   AST_SINGLE_RESPONDER: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_rvalid && eng_rvalid)); // R9

   AST_ENG_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rd |=> eng_rvalid); // R8

endmodule

bind xbuf_top xbuf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_sel    (cpu_sel),
   .cpu_wr     (cpu_wr),
   .cpu_addr   (cpu_addr),
   .cpu_wdata  (cpu_wdata),
   .cpu_stall  (cpu_stall),
   .cpu_rvalid (cpu_rvalid),
   .eng_wr     (eng_wr),
   .eng_rd     (eng_rd),
   .eng_rvalid (eng_rvalid),
   .wr_ptr     (wr_ptr),
   .rd_ptr     (rd_ptr)
);

// File: tb/xbuf_top_tb.sv
module xbuf_top_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cpu_sel, cpu_wr;
   logic [1:0] cpu_addr;
   logic [7:0] cpu_wdata, cpu_rdata;
   logic       cpu_rvalid, cpu_stall;
   logic       eng_wr, eng_rd, eng_rvalid;
   logic [7:0] eng_wdata, eng_rdata;

   always #5 clk = ~clk;

   xbuf_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_rvalid(cpu_rvalid), .cpu_stall(cpu_stall),
      .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_rd(eng_rd),
      .eng_rdata(eng_rdata), .eng_rvalid(eng_rvalid)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int last_stalls = 0;

   logic [7:0] model [256];
   logic [7:0] mw = 8'd0;
   logic [7:0] mr = 8'd0;

   logic [7:0] cq [$];
   string      ctag [$];
   logic [7:0] eq [$];
   string      etag [$];

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: compare each response with the next expected item
   always @(negedge clk) begin
      if (rst_n && cpu_rvalid) begin
         if (cq.size() == 0) check("R4 unexpected cpu_rvalid", 8'd1, 8'd0);
         else check(ctag.pop_front(), cpu_rdata, cq.pop_front());
      end
      if (rst_n && eng_rvalid) begin
         if (eq.size() == 0) check("R8 unexpected eng_rvalid", 8'd1, 8'd0);
         else check(etag.pop_front(), eng_rdata, eq.pop_front());
      end
   end

   // Driver: CPU access, held through stalls; expected result queued on acceptance
   task automatic cpu_op(input bit wr, input logic [1:0] a, input logic [7:0] d, input string tag);
      bit st;
      int stalls = 0;
      cpu_sel = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
      forever begin
         @(negedge clk); st = cpu_stall;
         @(posedge clk); #1;
         if (!st) break;
         stalls++;
      end
      cpu_sel = 1'b0; cpu_wr = 1'b0;
      last_stalls = stalls;
      if (wr) begin
         case (a)
            2'd0: begin model[mw] = d; mw = mw + 8'd1; end
            2'd1: mw = d;
            2'd2: mr = d;
            default: ;
         endcase
      end else begin
         ctag.push_back(tag);
         case (a)
            2'd0: begin cq.push_back(model[mr]); mr = mr + 8'd1; end
            2'd1: cq.push_back(mw);
            2'd2: cq.push_back(mr);
            default: cq.push_back(8'd0);
         endcase
      end
   endtask

   task automatic eng_op(input bit w, input bit r, input logic [7:0] d, input string tag);
      eng_wr = w; eng_rd = r; eng_wdata = d;
      if (r) begin eq.push_back(model[mr]); etag.push_back(tag); end
      if (w) begin model[mw] = d; mw = mw + 8'd1; end
      if (r) mr = mr + 8'd1;
      @(posedge clk); #1;
      eng_wr = 1'b0; eng_rd = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      check("watchdog expired", 8'd1, 8'd0);
      summary();
   end

   initial begin
      rst_n = 1'b0; cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_addr = 2'd0; cpu_wdata = 8'd0;
      eng_wr = 1'b0; eng_rd = 1'b0; eng_wdata = 8'd0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check("R1 cpu_rvalid after reset", {7'd0, cpu_rvalid}, 8'd0);
      check("R1 eng_rvalid after reset", {7'd0, eng_rvalid}, 8'd0);
      @(posedge clk); #1;
      cpu_op(0, 2'd1, 8'd0, "R1 wptr reset");
      cpu_op(0, 2'd2, 8'd0, "R1 rptr reset");

      // R3/R4: FIFO usage
      for (int i = 0; i < 4; i++) cpu_op(1, 2'd0, 8'h10 + 8'(i * 3), "R3 write");
      cpu_op(0, 2'd1, 8'd0, "R5 wptr after 4 writes");
      for (int i = 0; i < 4; i++) cpu_op(0, 2'd0, 8'd0, "R4 fifo read");
      cpu_op(0, 2'd2, 8'd0, "R5 rptr after 4 reads");
      // R4: single-cycle response pulse
      @(negedge clk);
      @(negedge clk);
      check("R4 cpu_rvalid one cycle", {7'd0, cpu_rvalid}, 8'd0);
      @(posedge clk); #1;

      // R6: direct access
      cpu_op(1, 2'd1, 8'h80, "R6 load wptr");
      cpu_op(1, 2'd0, 8'hA5, "R6 write");
      cpu_op(1, 2'd0, 8'h5C, "R6 write");
      cpu_op(1, 2'd2, 8'h81, "R6 load rptr");
      cpu_op(0, 2'd0, 8'd0, "R6 direct read 0x81");
      cpu_op(1, 2'd2, 8'h80, "R6 load rptr");
      cpu_op(0, 2'd0, 8'd0, "R6 direct read 0x80");

      // R2: unused select
      cpu_op(1, 2'd3, 8'h33, "R2 write unused");
      cpu_op(0, 2'd3, 8'd0, "R2 read unused");
      cpu_op(0, 2'd1, 8'd0, "R2 wptr untouched");
      cpu_op(0, 2'd2, 8'd0, "R2 rptr untouched");

      // R7: wrap
      cpu_op(1, 2'd1, 8'hFF, "R7 load wptr");
      cpu_op(1, 2'd0, 8'h11, "R7 write at 255");
      cpu_op(1, 2'd0, 8'h22, "R7 write at 0");
      cpu_op(0, 2'd1, 8'd0, "R7 wptr wrapped");
      cpu_op(1, 2'd2, 8'hFF, "R7 load rptr");
      cpu_op(0, 2'd0, 8'd0, "R7 read at 255");
      cpu_op(0, 2'd0, 8'd0, "R7 read at 0");
      cpu_op(0, 2'd2, 8'd0, "R7 rptr wrapped");

      // R8: engine strobes on the shared pointers
      cpu_op(1, 2'd1, 8'h20, "R8 load wptr");
      eng_op(1, 0, 8'h71, "R8 eng write");
      eng_op(1, 0, 8'h72, "R8 eng write");
      eng_op(1, 0, 8'h73, "R8 eng write");
      cpu_op(0, 2'd1, 8'd0, "R8 wptr after engine writes");
      cpu_op(1, 2'd2, 8'h20, "R8 load rptr");
      eng_op(0, 1, 8'd0, "R8 eng read");
      eng_op(0, 1, 8'd0, "R8 eng read");
      cpu_op(0, 2'd0, 8'd0, "R8 cpu read after engine reads");

      // R9: same-cycle conflict, engine first
      cpu_op(1, 2'd1, 8'h30, "R9 load wptr");
      fork
         eng_op(1, 0, 8'hE1, "R9 eng write");
         cpu_op(1, 2'd0, 8'hC1, "R9 cpu write");
      join
      check("R9 stall cycles", 8'(last_stalls), 8'd1);
      cpu_op(1, 2'd2, 8'h30, "R9 load rptr");
      cpu_op(0, 2'd0, 8'd0, "R9 engine byte first");
      cpu_op(0, 2'd0, 8'd0, "R9 cpu byte second");
      fork
         eng_op(0, 1, 8'd0, "R9 eng read in conflict");
         cpu_op(0, 2'd1, 8'd0, "R9 cpu read after stall");
      join
      check("R9 stall cycles on read", 8'(last_stalls), 8'd1);

      // R10: engine read and write to the same position
      cpu_op(1, 2'd1, 8'h40, "R10 load wptr");
      cpu_op(1, 2'd0, 8'h5A, "R10 seed");
      cpu_op(1, 2'd1, 8'h40, "R10 load wptr");
      cpu_op(1, 2'd2, 8'h40, "R10 load rptr");
      eng_op(1, 1, 8'hC3, "R10 old byte returned");
      cpu_op(1, 2'd2, 8'h40, "R10 load rptr");
      cpu_op(0, 2'd0, 8'd0, "R10 new byte stored");

      repeat (3) @(posedge clk);
      check("R4 all cpu responses seen", 8'(cq.size()), 8'd0);
      check("R8 all engine responses seen", 8'(eq.size()), 8'd0);
      summary();
   end

endmodule